// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous request port and an external asynchronous static memory with a 16-bit data path split into two byte lanes. A requester offers one read or one write per handshake. The sequencer turns each request into a memory cycle whose phases last a programmed number of system clocks. The phases are address setup, strobe, hold and, after reads, bus turnaround. This lets one netlist meet the access, pulse-width and setup rules of whichever speed grade is fitted.

Writes are controlled by the write-enable pin. The address, chip enable, byte enables and write data become valid first. Write enable then falls for the pulse width and rises while everything else is still held, so the rising edge commits the word. Reads lower output enable for the access window. The sequencer samples the data bus on the last clock of that window and returns the word with a one-cycle valid strobe. Lanes that the request did not enable read back as zero. Between requests chip enable stays high, so the memory rests in standby. The controller releases the shared bus while the memory may still be driving it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, and whenever idle, chip enable, write enable, output enable and both active-low byte enables are high, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only while no memory cycle is in progress. A `req_valid` raised while `req_ready` is low has no effect: no memory cycle and no change to memory contents.
- R3: Before write enable falls, or before output enable falls, chip enable is low with the address held for exactly `T_SETUP` clocks.
- R4: Write enable stays low for exactly `T_PULSE` consecutive clocks, and the address does not change while it is low.
- R5: When write enable rises, chip enable is still low and the address and write data are unchanged. The word written is the one presented with the request.
- R6: Output enable stays low for exactly `T_ACCESS` clocks. The returned word is the bus value in the last of those clocks.
- R7: Each read produces exactly one `rsp_valid` pulse, one clock long, in the clock after output enable rises. Writes produce none.
- R8: `req_be[0]` enables data bits 7:0 and `req_be[1]` enables bits 15:8. On writes, only the enabled lanes of the stored word change. On reads, disabled lanes return zero.
- R9: After a read's hold clock, chip enable stays high and `req_ready` stays low for exactly `T_TURN` clocks. The controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this clock (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_be | input | LANES | Lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read word valid (one clock) |
| rsp_rdata | output | DATA_W | Read word, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES | Byte enables, active low, bit 0 = bits 7:0 |
| mem_dq | inout | DATA_W | Shared data bus |

## Verification
The bench models a memory whose output is junk until output enable has been low for the full access window. A sequencer that sampled one clock early would therefore return wrong words instead of slipping through. It measures each setup, pulse, access and turnaround run in clocks, so an off-by-one counter shows up as a wrong length rather than as a subtle data error. Partial-lane writes followed by full reads catch lane enables that are swapped or ignored. A request raised during a busy cycle and then withdrawn must leave memory untouched. A sequencer that let it through would corrupt the target word.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_SETUP  = 3'd1,
      SQ_STROBE = 3'd2,
      SQ_HOLD   = 3'd3,
      SQ_TURN   = 3'd4
   } sq_state_e;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int T_SETUP  = 1,
   parameter int T_PULSE  = 1,
   parameter int T_ACCESS = 1,
   parameter int T_TURN   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             fire_write,
   input  logic             expired,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output sq_state_e        state,
   output logic             is_wr,
   output logic             capture
);
   localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(T_SETUP - 1);
   localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(T_PULSE - 1);
   localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(T_ACCESS - 1);
   localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(T_TURN - 1);

   sq_state_e state_q, state_d;
   logic      wr_q;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      unique case (state_q)
         SQ_IDLE: if (fire) begin
            state_d  = SQ_SETUP;
            load     = 1'b1;
            load_val = LD_SETUP;
         end
         SQ_SETUP: if (expired) begin
            state_d  = SQ_STROBE;
            load     = 1'b1;
            load_val = wr_q ? LD_PULSE : LD_ACCESS;
         end
         SQ_STROBE: if (expired) state_d = SQ_HOLD;
         SQ_HOLD: begin
            if (wr_q) begin
               state_d = SQ_IDLE;
            end else begin
               state_d  = SQ_TURN;
               load     = 1'b1;
               load_val = LD_TURN;
            end
         end
         SQ_TURN: if (expired) state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE && fire) wr_q <= fire_write;
      end
   end

   assign state   = state_q;
   assign is_wr   = wr_q;
   assign capture = (state_q == SQ_STROBE) && !wr_q && expired;
endmodule

// File: rtl/sram_seq_lanes.sv
module sram_seq_lanes #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              active,
   input  logic [LANES-1:0]  be_q,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata,
   output logic [LANES-1:0]  be_n
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= '0;
         else if (capture)
            lane_q <= be_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end

      assign rdata[g*LANE_W +: LANE_W] = lane_q;
      assign be_n[g] = !(active && be_q[g]);
   end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LANES    = 2,
   parameter int LANE_W   = 8,
   parameter int T_SETUP  = 1,
   parameter int T_PULSE  = 2,
   parameter int T_ACCESS = 2,
   parameter int T_TURN   = 1,
   localparam int DATA_W  = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_be_n,
   inout  wire  [DATA_W-1:0] mem_dq
);
   localparam int T_MAX = int'(max_of4(T_SETUP, T_PULSE, T_ACCESS, T_TURN));
   localparam int CNT_W = $clog2(T_MAX + 1);

   if (T_SETUP < 1 || T_PULSE < 1 || T_ACCESS < 1 || T_TURN < 1) begin : g_bad_timing
      $error("every phase length must be at least one clock");
   end
   if (ADDR_W < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_shape
      $error("address and lane widths must be positive");
   end

   sq_state_e         state;
   logic              is_wr, capture, expired, load, fire, active, dq_drive;
   logic [CNT_W-1:0]  load_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;

   assign req_ready = (state == SQ_IDLE);
   assign fire      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else if (fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
      end
   end

   sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
   );

   sram_seq_fsm #(
      .CNT_W(CNT_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
      .T_ACCESS(T_ACCESS), .T_TURN(T_TURN)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .fire(fire), .fire_write(req_write),
      .expired(expired), .load(load), .load_val(load_val),
      .state(state), .is_wr(is_wr), .capture(capture)
   );

   assign active = (state == SQ_SETUP) || (state == SQ_STROBE) || (state == SQ_HOLD);

   sram_seq_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .capture(capture), .active(active),
      .be_q(be_q), .dq_in(mem_dq), .rdata(rsp_rdata), .be_n(mem_be_n)
   );

   assign mem_addr  = addr_q;
   assign mem_ce_n  = !active;
   assign mem_we_n  = !((state == SQ_STROBE) && is_wr);
   assign mem_oe_n  = !((state == SQ_STROBE) && !is_wr);
   assign rsp_valid = (state == SQ_HOLD) && !is_wr;
   assign dq_drive  = active && is_wr;
   assign mem_dq    = dq_drive ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              dq_drive
);
   a_r2_ready_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n);

   a_r3_ce_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_ce_n));

   a_r3_ce_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $past(!mem_ce_n));

   a_r4_addr_stable_we_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

   a_r5_ce_low_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_ce_n);

   a_r5_addr_held_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> $stable(mem_addr));

   a_r7_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r7_valid_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(mem_oe_n));

   a_r9_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(dq_drive && !mem_oe_n));

   a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
   .mem_addr(mem_addr), .dq_drive(dq_drive)
);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int TS = 2;
   localparam int TP = 3;
   localparam int TA = 3;
   localparam int TT = 2;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_be_n;
   wire  [DW-1:0] mem_dq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = !clk;

   sram_seq_ctrl #(
      .ADDR_W(AW), .LANES(2), .LANE_W(8),
      .T_SETUP(TS), .T_PULSE(TP), .T_ACCESS(TA), .T_TURN(TT)
   ) u_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq(mem_dq)
   );

   // memory model: output is junk until OE has been low for the access window
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] expv [DEPTH];
   int            oe_cnt = 0;
   logic          mdl_drive;
   logic [DW-1:0] mdl_data;

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_oe_n) oe_cnt <= oe_cnt + 1;
      else oe_cnt <= 0;
   end
   assign mdl_drive = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mdl_data  = (oe_cnt >= TA - 1) ? mem[mem_addr] : 16'h5A5A;
   assign mem_dq    = mdl_drive ? mdl_data : 16'hzzzz;

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce_n) begin
         if (!mem_be_n[0]) mem[mem_addr][7:0]  <= mem_dq[7:0];
         if (!mem_be_n[1]) mem[mem_addr][15:8] <= mem_dq[15:8];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // phase monitor, sampled at falling edges
   int            setup_run = 0, we_run = 0, oe_run = 0, turn_run = 0;
   bit            strobed = 0, prev_we_n = 1, prev_oe_n = 1, prev_rsp = 0, turn_act = 0;
   bit            last_wr = 0, turn_ce_bad = 0;
   logic [AW-1:0] addr_at_we = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_ce_n) chk("R2 ready low while busy", req_ready, 0);
         if (mem_ce_n) begin
            setup_run = 0; strobed = 0;
         end else if (mem_we_n && mem_oe_n && !strobed) begin
            setup_run++;
         end
         if ((!mem_we_n || !mem_oe_n) && prev_we_n && prev_oe_n) begin
            chk("R3 setup clocks", setup_run, TS);
            strobed = 1;
         end
         if (!mem_we_n) begin
            if (prev_we_n) addr_at_we = mem_addr;
            we_run++;
         end else if (!prev_we_n) begin
            chk("R4 write pulse clocks", we_run, TP);
            chk("R5 ce low at we rise", mem_ce_n, 0);
            chk("R5 address held at we rise", mem_addr, addr_at_we);
            we_run = 0;
         end
         if (!mem_oe_n) oe_run++;
         else if (!prev_oe_n) begin
            chk("R6 oe low clocks", oe_run, TA);
            oe_run = 0;
         end
         if (rsp_valid) begin
            chk("R7 rsp only after oe rise", prev_oe_n, 0);
            chk("R7 rsp one clock", prev_rsp, 0);
            chk("R7 no rsp on write", last_wr, 0);
            turn_act = 1; turn_run = 0; turn_ce_bad = 0;
         end else if (turn_act) begin
            if (req_ready) begin
               chk("R9 turnaround clocks", turn_run, TT);
               chk("R9 ce high in turnaround", turn_ce_bad, 0);
               turn_act = 0;
            end else begin
               turn_run++;
               if (!mem_ce_n) turn_ce_bad = 1;
            end
         end
         prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_rsp = rsp_valid;
      end
   end

   task automatic issue(input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] be);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      last_wr = wr;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
      issue(1'b1, a, d, be);
      if (be[0]) expv[a][7:0]  = d[7:0];
      if (be[1]) expv[a][15:8] = d[15:8];
      while (!req_ready) @(negedge clk);
   endtask

   task automatic rd_word(input logic [AW-1:0] a, input logic [1:0] be, input string tag);
      logic [DW-1:0] want;
      issue(1'b0, a, '0, be);
      while (!rsp_valid) @(negedge clk);
      want = {be[1] ? expv[a][15:8] : 8'h00, be[0] ? expv[a][7:0] : 8'h00};
      chk(tag, rsp_rdata, want);
      while (!req_ready) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return DW'((a * 16'h1357 + k * 16'h0F1F) ^ 16'hA5C3);
   endfunction

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i]  = DW'(i * 16'h0101) ^ 16'hFFFF;
         expv[i] = DW'(i * 16'h0101) ^ 16'hFFFF;
      end
      repeat (3) @(negedge clk);
      chk("R1 reset ce_n", mem_ce_n, 1);
      chk("R1 reset we_n", mem_we_n, 1);
      chk("R1 reset oe_n", mem_oe_n, 1);
      chk("R1 reset be_n", mem_be_n, 2'b11);
      chk("R1 reset ready", req_ready, 1);
      chk("R1 reset rsp_valid", rsp_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle outputs", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);

      // R5 R6 full-word sweep
      for (int a = 0; a < DEPTH; a++) wr_word(AW'(a), pat(a, 1), 2'b11);
      for (int a = 0; a < DEPTH; a++) rd_word(AW'(a), 2'(a % 3 + 1), "R6 R8 read lanes");

      // R8 partial-lane writes, full readback
      for (int a = 0; a < DEPTH; a++) wr_word(AW'(a), pat(a, 7), (a % 2 == 0) ? 2'b01 : 2'b10);
      for (int a = 0; a < DEPTH; a++) rd_word(AW'(a), 2'b11, "R8 partial write readback");

      // R2 request raised while busy must be ignored
      issue(1'b0, 6'd5, '0, 2'b11);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 6'd9; req_wdata = 16'h1234; req_be = 2'b11;
      chk("R2 ready low during busy request", req_ready, 0);
      repeat (2) @(negedge clk);
      chk("R2 ready still low", req_ready, 0);
      req_valid = 0;
      while (!req_ready) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R2 no cycle after withdrawn request", mem_ce_n, 1);
      rd_word(6'd9, 2'b11, "R2 memory untouched by busy request");
      rd_word(6'd9, 2'b00, "R8 no lanes read zero");

      repeat (4) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule